// File: doc/BRIEF.md
# Selectable-Source Fractional Clock Divider

This block is one slice of a clock generator. It watches ten clock-enable inputs, all in one system clock domain, and picks one of them through a control word. It divides the chosen stream by a fixed-point divisor. The result is a strobe whose long-run rate is the source rate times 2^FRAC_BITS divided by the divisor. The division uses a phase accumulator, so pulses are spread as evenly as whole source pulses allow.

Software reaches the slice through a small register port with two words. The control word holds the source selector, an enable bit and a read-only busy flag. The divisor word holds an unsigned fixed-point value. Its integer field always starts at bit 12 and grows upward. Its fractional field lies just below bit 12. The widths of the two fields are elaboration parameters. When both widths are zero, the divider is left out and the chosen source passes straight through.

Top module: `clk_mux_frac_div`

## Requirements
- R1: With enable set and selector value s in 0..9, only pulses on src_pulse[s] can make output pulses. Pulses on any other source have no effect on the output or on the divider phase.
- R2: Selector values 10 to 15 select no source, and the output stays low.
- R3: While the enable bit is clear, out_pulse stays low.
- R4: Control word layout (wr_addr/rd_addr = 0): selector in bits [3:0], enable in bit 4, busy in bit 7, all other bits read as zero. Busy always reads equal to enable, and a value written to bit 7 is ignored.
- R5: Divisor word (address 1): the divisor D is the unsigned value in bits [12+INT_BITS-1 : 12-FRAC_BITS], with the integer part above the fractional part. Reading the word returns D at that position and zero in every other bit.
- R6: When D is zero, out_pulse stays low.
- R7: Counting selected pulses k = 1, 2, ... from the last register write, the k-th selected pulse gives an output pulse exactly when floor(k*2^FRAC_BITS/D) > floor((k-1)*2^FRAC_BITS/D). out_pulse is high for the one cycle after that source pulse.
- R8: When 1 <= D <= 2^FRAC_BITS, every selected pulse gives an output pulse, so the output never runs faster than the source.
- R9: With INT_BITS = FRAC_BITS = 0, each selected pulse appears on out_pulse one cycle later, regardless of the divisor word.
- R10: A write to either register clears the divider phase and suppresses output in the following cycle.
- R11: After reset both registers read zero and out_pulse is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_pulse | input | NUM_SRC | One enable pulse per source clock edge, one bit per source |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | Write target: 0 control, 1 divisor |
| wr_data | input | 32 | Write data |
| rd_addr | input | 1 | Read target: 0 control, 1 divisor |
| rd_data | output | 32 | Read data, combinational from rd_addr |
| out_pulse | output | 1 | Divided output strobe |

## Verification
The hardest thing to reach from the ports is the hidden phase of the accumulator. It depends on how many selected pulses have arrived since the last write. Pulses on unselected sources must not move it, and a write must reset it. The stimulus writes each divisor value in turn and then alternates selected and unselected pulses, so every output can be compared with the floor formula for the selected pulse count. A separate sequence leaves a known remainder in the accumulator, rewrites the same divisor, and shows that the pulse the old remainder would have produced does not appear.

// File: rtl/cmx_pkg.sv
// Package: shared register addresses and bit positions for the clock
// source mux / fractional divider slice.
// Assumes a one-bit register address space (two words).
package cmx_pkg;
    localparam int unsigned REG_W        = 32;
    localparam int unsigned SEL_W        = 4;
    localparam logic        ADDR_CTL     = 1'b0;
    localparam logic        ADDR_DIV     = 1'b1;
    localparam int unsigned CTL_EN_BIT   = 4;
    localparam int unsigned CTL_BUSY_BIT = 7;
    localparam int unsigned DIV_INT_LSB  = 12;

    // Holds the live configuration seen by the datapath.
    typedef struct packed {
        logic [SEL_W-1:0] sel;
        logic             en;
    } ctl_t;

    // Builds the control word as it is read back: busy follows enable.
    function automatic logic [REG_W-1:0] pack_ctl(input ctl_t c);
        logic [REG_W-1:0] w;
        w = '0;
        w[SEL_W-1:0]    = c.sel;
        w[CTL_EN_BIT]   = c.en;
        w[CTL_BUSY_BIT] = c.en;
        return w;
    endfunction
endpackage

// File: rtl/cmx_regs.sv
// Module: cmx_regs
// Holds the control word and the divisor field. Busy is not stored; it is
// derived from enable on readback, so writes to it vanish. The divisor
// field is taken from bits [12+INT_BITS-1 : 12-FRAC_BITS] of the write data.
// Assumes FRAC_BITS <= 12 and INT_BITS <= 20.
module cmx_regs
    import cmx_pkg::*;
#(
    parameter int unsigned INT_BITS  = 4,
    parameter int unsigned FRAC_BITS = 2,
    localparam int unsigned DW       = INT_BITS + FRAC_BITS,
    localparam int unsigned DIV_W    = (DW == 0) ? 1 : DW,
    localparam int unsigned FLD_LSB  = DIV_INT_LSB - FRAC_BITS
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             wr_addr,
    input  logic [REG_W-1:0] wr_data,
    input  logic             rd_addr,
    output logic [REG_W-1:0] rd_data,
    output ctl_t             ctl,
    output logic [DIV_W-1:0] div,
    output logic             cfg_wr
);
    ctl_t             ctl_q;
    logic [REG_W-1:0] rd_div;

    // Control register update: selector and enable only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else if (wr_en && wr_addr == ADDR_CTL) begin
            ctl_q.sel <= wr_data[SEL_W-1:0];
            ctl_q.en  <= wr_data[CTL_EN_BIT];
        end
    end

    generate
        if (DW == 0) begin : g_no_div
            // No divisor field exists in this configuration.
            assign div    = '0;
            assign rd_div = '0;
        end else begin : g_div
            logic [DIV_W-1:0] div_q;

            // Divisor register update: extract the packed fixed-point field.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    div_q <= '0;
                end else if (wr_en && wr_addr == ADDR_DIV) begin
                    div_q <= wr_data[FLD_LSB +: DIV_W];
                end
            end

            assign div = div_q;

            // Readback places the field back at its bit position.
            always_comb rd_div = REG_W'(div_q) << FLD_LSB;
        end
    endgenerate

    // Read multiplexer.
    always_comb rd_data = (rd_addr == ADDR_CTL) ? pack_ctl(ctl_q) : rd_div;

    assign ctl    = ctl_q;
    assign cfg_wr = wr_en;
endmodule

// File: rtl/cmx_src_sel.sv
// Module: cmx_src_sel
// Picks the pulse of the source named by the selector. Selector values at
// or above NUM_SRC decode to no source and give a constant zero.
// Assumes NUM_SRC <= 2**SEL_W.
module cmx_src_sel
    import cmx_pkg::*;
#(
    parameter int unsigned NUM_SRC = 10
) (
    input  logic [NUM_SRC-1:0] src_pulse,
    input  logic [SEL_W-1:0]   sel,
    output logic               sel_pulse
);
    logic [NUM_SRC-1:0] hit;

    generate
        for (genvar i = 0; i < NUM_SRC; i++) begin : g_dec
            // One comparator per source.
            assign hit[i] = src_pulse[i] && (sel == SEL_W'(i));
        end
    endgenerate

    // At most one bit of hit can be set, so OR-reduction selects it.
    always_comb sel_pulse = |hit;
endmodule

// File: rtl/cmx_phase_div.sv
// Module: cmx_phase_div
// Divides the selected pulse stream. Each selected pulse adds 2^FRAC_BITS
// to a phase accumulator; when it reaches the divisor, the divisor is
// taken away and one output pulse is registered. A divisor at or below
// 2^FRAC_BITS passes every pulse. With zero field widths it is a plain
// one-cycle pass-through. Any register write clears the phase.
module cmx_phase_div #(
    parameter int unsigned INT_BITS  = 4,
    parameter int unsigned FRAC_BITS = 2,
    localparam int unsigned DW       = INT_BITS + FRAC_BITS,
    localparam int unsigned DIV_W    = (DW == 0) ? 1 : DW,
    localparam int unsigned ACC_W    = DIV_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sel_pulse,
    input  logic             en,
    input  logic             cfg_wr,
    input  logic [DIV_W-1:0] div,
    output logic [ACC_W-1:0] acc,
    output logic             out_pulse
);
    logic out_q;

    generate
        if (DW == 0) begin : g_bypass
            // Pass-through: register the gated selected pulse.
            always_ff @(posedge clk) begin
                if (!rst_n) out_q <= 1'b0;
                else        out_q <= sel_pulse && en && !cfg_wr;
            end
            assign acc = '0;
        end else begin : g_accum
            localparam logic [ACC_W-1:0] STEP = ACC_W'(1) << FRAC_BITS;
            logic [ACC_W-1:0] acc_q;
            logic [ACC_W-1:0] sum;
            logic [ACC_W-1:0] div_x;

            // Next phase if this pulse is counted.
            always_comb begin
                div_x = ACC_W'(div);
                sum   = acc_q + STEP;
            end

            // Phase accumulator and output strobe.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    acc_q <= '0;
                    out_q <= 1'b0;
                end else if (cfg_wr) begin
                    acc_q <= '0;
                    out_q <= 1'b0;
                end else if (en && sel_pulse && div_x != '0) begin
                    if (div_x <= STEP) begin
                        acc_q <= '0;
                        out_q <= 1'b1;
                    end else if (sum >= div_x) begin
                        acc_q <= sum - div_x;
                        out_q <= 1'b1;
                    end else begin
                        acc_q <= sum;
                        out_q <= 1'b0;
                    end
                end else begin
                    out_q <= 1'b0;
                end
            end

            assign acc = acc_q;
        end
    endgenerate

    assign out_pulse = out_q;
endmodule

// File: rtl/clk_mux_frac_div.sv
// Module: clk_mux_frac_div (top)
// Clock generator slice: register port, source selector and fractional
// divider. All sources are enable pulses in the clk domain.
// Assumes NUM_SRC <= 16, FRAC_BITS <= 12, INT_BITS <= 20.
module clk_mux_frac_div
    import cmx_pkg::*;
#(
    parameter int unsigned NUM_SRC   = 10,
    parameter int unsigned INT_BITS  = 4,
    parameter int unsigned FRAC_BITS = 2,
    localparam int unsigned DW       = INT_BITS + FRAC_BITS,
    localparam int unsigned DIV_W    = (DW == 0) ? 1 : DW,
    localparam int unsigned ACC_W    = DIV_W + 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_pulse,
    input  logic               wr_en,
    input  logic               wr_addr,
    input  logic [31:0]        wr_data,
    input  logic               rd_addr,
    output logic [31:0]        rd_data,
    output logic               out_pulse
);
    ctl_t             cfg_ctl;
    logic [DIV_W-1:0] cfg_div;
    logic             cfg_wr;
    logic             sel_pulse;
    logic [ACC_W-1:0] acc_val;

    cmx_regs #(
        .INT_BITS (INT_BITS),
        .FRAC_BITS(FRAC_BITS)
    ) regs_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en),
        .wr_addr(wr_addr),
        .wr_data(wr_data),
        .rd_addr(rd_addr),
        .rd_data(rd_data),
        .ctl    (cfg_ctl),
        .div    (cfg_div),
        .cfg_wr (cfg_wr)
    );

    cmx_src_sel #(
        .NUM_SRC(NUM_SRC)
    ) sel_i (
        .src_pulse(src_pulse),
        .sel      (cfg_ctl.sel),
        .sel_pulse(sel_pulse)
    );

    cmx_phase_div #(
        .INT_BITS (INT_BITS),
        .FRAC_BITS(FRAC_BITS)
    ) div_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .sel_pulse(sel_pulse),
        .en       (cfg_ctl.en),
        .cfg_wr   (cfg_wr),
        .div      (cfg_div),
        .acc      (acc_val),
        .out_pulse(out_pulse)
    );
endmodule

// File: rtl/cmx_chk.sv
// Module: cmx_chk
// Property checker for clk_mux_frac_div, attached with bind below.
module cmx_chk #(
    parameter int unsigned NUM_SRC   = 10,
    parameter int unsigned INT_BITS  = 4,
    parameter int unsigned FRAC_BITS = 2,
    localparam int unsigned DW       = INT_BITS + FRAC_BITS,
    localparam int unsigned DIV_W    = (DW == 0) ? 1 : DW,
    localparam int unsigned ACC_W    = DIV_W + 1
) (
    input logic               clk,
    input logic               rst_n,
    input logic [NUM_SRC-1:0] src_pulse,
    input logic               wr_en,
    input logic               rd_addr,
    input logic [31:0]        rd_data,
    input logic               out_pulse,
    input logic [3:0]         sel,
    input logic               en,
    input logic [DIV_W-1:0]   div,
    input logic [ACC_W-1:0]   acc
);
    localparam bit HAS_DIV = (DW > 0);
    logic [15:0] src_ext;
    logic        chosen;

    // Independent view of the chosen source, widened to the selector range.
    always_comb begin
        src_ext = 16'(src_pulse);
        chosen  = (sel < 4'(NUM_SRC)) && src_ext[sel];
    end

    AST_OUT_FROM_CHOSEN: assert property (@(posedge clk) disable iff (!rst_n)
        out_pulse |-> $past(chosen)); // R1
    AST_BAD_SEL_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        $past(sel >= 4'(NUM_SRC)) && !$past(wr_en) |-> !out_pulse); // R2
    AST_DISABLED_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        out_pulse |-> $past(en)); // R3
    AST_BUSY_MIRROR: assert property (@(posedge clk) disable iff (!rst_n)
        rd_addr == 1'b0 |-> rd_data[7] == rd_data[4]); // R4
    AST_ZERO_DIV_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        HAS_DIV && $past(div == '0) |-> !out_pulse); // R6
    AST_PHASE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        acc == '0 || ACC_W'(div) > acc); // R7
    AST_WRITE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        $past(wr_en) |-> acc == '0 && !out_pulse); // R10
endmodule

bind clk_mux_frac_div cmx_chk #(
    .NUM_SRC  (NUM_SRC),
    .INT_BITS (INT_BITS),
    .FRAC_BITS(FRAC_BITS)
) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .src_pulse(src_pulse),
    .wr_en    (wr_en),
    .rd_addr  (rd_addr),
    .rd_data  (rd_data),
    .out_pulse(out_pulse),
    .sel      (cfg_ctl.sel),
    .en       (cfg_ctl.en),
    .div      (cfg_div),
    .acc      (acc_val)
);

// File: tb/clk_mux_frac_div_tb_top.sv
// Bench: sweeps every divisor and selector of a small configuration
// (INT_BITS=4, FRAC_BITS=2) plus a zero-width pass-through instance, with
// expected outputs from the floor formula.
module clk_mux_frac_div_tb_top;
    localparam int NSRC = 10;
    localparam int FB   = 2;
    localparam int IB   = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [NSRC-1:0] src_pulse = '0;
    logic        wr_en = 1'b0;
    logic        wr_addr = 1'b0;
    logic [31:0] wr_data = '0;
    logic        rd_addr = 1'b0;
    logic [31:0] rd_a, rd_b;
    logic        out_a, out_b;
    int          n_cmp = 0;
    int          n_bad = 0;
    bit          done = 1'b0;

    always #10 clk = ~clk; // 50 MHz

    clk_mux_frac_div #(.NUM_SRC(NSRC), .INT_BITS(IB), .FRAC_BITS(FB)) dut_i (
        .clk(clk), .rst_n(rst_n), .src_pulse(src_pulse), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
        .rd_data(rd_a), .out_pulse(out_a));

    clk_mux_frac_div #(.NUM_SRC(NSRC), .INT_BITS(0), .FRAC_BITS(0)) dut_byp_i (
        .clk(clk), .rst_n(rst_n), .src_pulse(src_pulse), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
        .rd_data(rd_b), .out_pulse(out_b));

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic wr(input logic a, input logic [31:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic rd_check(input string req, input logic a, input logic [31:0] exp);
        rd_addr = a;
        #1;
        check(req, rd_a, exp);
    endtask

    // Drive one cycle of source pulses and check both outputs a cycle later.
    task automatic step(input logic [NSRC-1:0] p, input string req,
                        input logic ea, input logic eb);
        src_pulse = p;
        @(negedge clk);
        src_pulse = '0;
        check(req, 32'(out_a), 32'(ea));
        check({req, " bypass R9"}, 32'(out_b), 32'(eb));
    endtask

    function automatic logic fires(input int k, input int d);
        if (d == 0) return 1'b0;
        return ((k * (1 << FB)) / d) > (((k - 1) * (1 << FB)) / d);
    endfunction

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11: reset state
        check("R11 out", 32'(out_a), 0);
        rd_check("R11 ctl", 1'b0, 32'h0);
        rd_check("R11 div", 1'b1, 32'h0);

        // R4: busy mirrors enable, writes to bit 7 ignored
        wr(1'b0, 32'h0000_0013);
        rd_check("R4 busy set", 1'b0, 32'h0000_0093);
        wr(1'b0, 32'hFFFF_FF63);
        rd_check("R4 busy write ignored", 1'b0, 32'h0000_0003);

        // R5: field placement [15:10]
        wr(1'b1, 32'hFFFF_FFFF);
        rd_check("R5 div mask", 1'b1, 32'h0000_FC00);
        wr(1'b1, 32'h0000_2C00);
        rd_check("R5 div value", 1'b1, 32'h0000_2C00);

        // R7/R6/R8/R1: every divisor, interleaved unselected pulses
        for (int d = 0; d < (1 << (IB + FB)); d++) begin
            int s;
            s = d % NSRC;
            wr(1'b1, 32'(d) << (12 - FB));
            wr(1'b0, 32'h10 | 32'(s));
            for (int k = 1; k <= 18; k++) begin
                step(NSRC'(1) << s, (d == 0) ? "R6 zero div" :
                     (d <= (1 << FB)) ? "R8 capped" : "R7 phase",
                     fires(k, d), 1'b1);
                step(NSRC'(1) << ((s + 1 + k % (NSRC - 1)) % NSRC),
                     "R1 unselected", 1'b0, 1'b0);
            end
            step('0, "R7 idle", 1'b0, 1'b0);
        end

        // R1/R2: every selector value against every source, D = 2^FB
        wr(1'b1, 32'(1 << FB) << (12 - FB));
        for (int sel = 0; sel < 16; sel++) begin
            wr(1'b0, 32'h10 | 32'(sel));
            for (int j = 0; j < NSRC; j++) begin
                logic e;
                e = (sel < NSRC) && (j == sel);
                step(NSRC'(1) << j, (sel >= NSRC) ? "R2 bad select" : "R1 select", e, e);
            end
        end

        // R3: disabled gives nothing
        wr(1'b0, 32'h0000_0002);
        for (int k = 0; k < 6; k++) step(NSRC'(4), "R3 disabled", 1'b0, 1'b0);

        // R10: leave phase 4 with D=7, rewrite, next pulse must not fire
        wr(1'b1, 32'd7 << (12 - FB));
        wr(1'b0, 32'h12);
        step(NSRC'(4), "R10 setup", 1'b0, 1'b1);
        wr(1'b1, 32'd7 << (12 - FB));
        step(NSRC'(4), "R10 div write clears", 1'b0, 1'b1);
        step(NSRC'(4), "R10 after clear", 1'b1, 1'b1);
        step(NSRC'(4), "R10 setup2", 1'b0, 1'b1);
        wr(1'b0, 32'h12);
        step(NSRC'(4), "R10 ctl write clears", 1'b0, 1'b1);
        // R10: pulse during the write cycle is dropped
        src_pulse = NSRC'(4);
        wr(1'b0, 32'h12);
        check("R10 write-cycle pulse", 32'(out_b), 0);

        if (!done) begin
            done = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule